// File: doc/BRIEF.md
# Address-Wake Asynchronous Serial Receiver

This block receives asynchronous serial frames on one line and delivers each byte to a holding register, with status flags and two interrupt request lines. It runs from a 16x oversampling enable. It waits for a falling edge on the idle-high line and confirms the start bit at its centre. It then samples every following bit at its centre. When the multiprocessor mode is selected, each frame carries one extra bit after the data byte. This bit marks the frame as an address (1) or as data (0).

Software can arm a wake filter so that a station on a shared line ignores traffic meant for other stations. While the filter is armed, data frames are dropped without trace: the holding register is not loaded, no flag is set and no interrupt is raised. The first address frame clears the armed bit in hardware. It records the extra bit in a status flag and is delivered like any other frame, so software can read the address and decide whether to stay awake. The arm bit has no effect when the multiprocessor mode is off. Turning the receiver off stops reception and leaves every flag as it was.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, the data register reads 0x00, and the data-full, framing-error, overrun, address-bit and wake-arm outputs all read 0.
- R2: A frame is a low start bit, then 8 data bits with the least significant bit first. When the multiprocessor mode is on, an address bit follows the data. One stop bit ends the frame. Each bit is sampled at its centre, counted in oversampling enables.
- R3: A low level that is high again at the start bit's centre is rejected as a glitch and delivers nothing.
- R4: A delivered frame loads the data register and sets data-full. The data-full clear strobe clears data-full.
- R5: A frame that completes while data-full is still set sets the overrun flag. The data register keeps its old value.
- R6: A stop bit sampled as 0 sets the framing-error flag. The error clear strobe clears both framing-error and overrun.
- R7: While the arm bit is 1 and the multiprocessor mode is on, a frame whose address bit is 0 changes neither the data register nor any flag, and raises no interrupt.
- R8: A frame whose address bit is 1 clears the arm bit, sets the address-bit flag and is delivered as in R4 to R6.
- R9: The arm-clear strobe clears both the arm bit and the address-bit flag.
- R10: When the multiprocessor mode is off, the arm bit has no effect. Frames are delivered and the arm bit keeps its value.
- R11: While receive enable is 0, no frame is received, and the data register and all flags hold their values.
- R12: The receive interrupt is high when data-full and the receive interrupt enable are both high. The error interrupt is high when framing-error or overrun is high and the error interrupt enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| os_tick_i | input | 1 | 16x oversampling enable |
| rx_en_i | input | 1 | Receive enable |
| mp_mode_i | input | 1 | Multiprocessor frame format (address bit present) |
| wake_set_i | input | 1 | Strobe: arm the wake filter |
| wake_clr_i | input | 1 | Strobe: disarm the wake filter and clear the address-bit flag |
| full_clr_i | input | 1 | Strobe: clear data-full |
| err_clr_i | input | 1 | Strobe: clear framing-error and overrun |
| rx_irq_en_i | input | 1 | Receive interrupt enable |
| err_irq_en_i | input | 1 | Error interrupt enable |
| rx_data_o | output | 8 | Received data register |
| full_o | output | 1 | Data-full flag |
| frame_err_o | output | 1 | Framing-error flag |
| overrun_o | output | 1 | Overrun flag |
| addr_bit_o | output | 1 | Received address-bit flag |
| wake_arm_o | output | 1 | Wake filter arm bit |
| rx_irq_o | output | 1 | Receive interrupt request |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The assertions check four rules on every cycle. A filtered frame leaves the data register and flags untouched. An address frame disarms the filter. An overrun keeps the old data. A disabled receiver produces no frame. The frame engine also drops a glitched start bit. Only the bench's frame scenarios show the bit order, the frame length with and without the address bit, the framing error, and that the arm bit is ignored outside multiprocessor mode. The bench also shows the interrupt outputs against their enables.

// File: rtl/mpurx_pkg.sv
// Shared types for the address-wake serial receiver.
package mpurx_pkg;
    // Frame engine states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/mpurx_sync.sv
// Synchroniser for the asynchronous serial line.
// Assumes the line idles high; the reset value is high so that reset does not look like a start bit.
module mpurx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic dout_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din_i};
    end

    assign dout_o = chain_q[STAGES-1];
endmodule

// File: rtl/mpurx_frame.sv
// Frame engine: finds the start bit, samples each bit at its centre and emits a one-cycle done pulse with the result.
// Assumes tick_i is the oversampling enable (OSR per bit). The multiprocessor mode is captured at the start bit.
module mpurx_frame
    import mpurx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              line_i,
    input  logic              mp_mode_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              mpbit_o,
    output logic              stop_ok_o
);
    localparam int CNT_W = $clog2(OSR);
    localparam int SH_W  = DATA_W + 1;
    localparam int BIT_W = $clog2(SH_W + 1);
    localparam logic [CNT_W-1:0] MID_C  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST_MP_C = BIT_W'(DATA_W);
    localparam logic [BIT_W-1:0] LAST_PL_C = BIT_W'(DATA_W - 1);

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BIT_W-1:0] bitn_q;
    logic [SH_W-1:0]  sh_q;
    logic             mp_q;
    logic             done_q;
    logic             stop_q;
    logic [BIT_W-1:0] last_bit;

    // Index of the final bit before the stop bit
    assign last_bit = mp_q ? LAST_MP_C : LAST_PL_C;

    // Sequence a frame on each oversampling enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            bitn_q  <= '0;
            sh_q    <= '0;
            mp_q    <= 1'b0;
            done_q  <= 1'b0;
            stop_q  <= 1'b0;
        end else if (!en_i) begin
            state_q <= RX_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick_i) begin
                case (state_q)
                    RX_IDLE: begin
                        if (!line_i) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                            mp_q    <= mp_mode_i;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == MID_C) begin
                            if (line_i) begin
                                state_q <= RX_IDLE;
                            end else begin
                                state_q <= RX_DATA;
                                cnt_q   <= '0;
                                bitn_q  <= '0;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == LAST_C) begin
                            cnt_q  <= '0;
                            sh_q   <= {line_i, sh_q[SH_W-1:1]};
                            bitn_q <= bitn_q + 1'b1;
                            if (bitn_q == last_bit) state_q <= RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == LAST_C) begin
                            done_q  <= 1'b1;
                            stop_q  <= line_i;
                            state_q <= RX_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    // Align the shifted bits to the frame length
    always_comb begin
        if (mp_q) begin
            data_o  = sh_q[DATA_W-1:0];
            mpbit_o = sh_q[SH_W-1];
        end else begin
            data_o  = sh_q[SH_W-1:1];
            mpbit_o = 1'b0;
        end
    end

    assign done_o    = done_q;
    assign stop_ok_o = stop_q;

    // R3: high line at the start-bit centre returns to idle
    p_glitch_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i && state_q == RX_START && cnt_q == MID_C && line_i) |=> (state_q == RX_IDLE && !done_q));

    // R11: a disabled receiver sits idle and completes no frame
    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == RX_IDLE && !done_q));
endmodule

// File: rtl/mpurx_status.sv
// Status and wake filter: takes completed frames, applies the address-wake filter, and keeps the data register and flags.
// Assumes done_i is a one-cycle pulse and that the software strobes are one-cycle pulses.
module mpurx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mpbit_i,
    input  logic              stop_ok_i,
    input  logic              mp_mode_i,
    input  logic              arm_set_i,
    input  logic              arm_clr_i,
    input  logic              full_clr_i,
    input  logic              err_clr_i,
    output logic [DATA_W-1:0] data_o,
    output logic              full_o,
    output logic              ferr_o,
    output logic              ovr_o,
    output logic              mpb_o,
    output logic              arm_o
);
    logic [DATA_W-1:0] data_q;
    logic full_q, ferr_q, ovr_q, mpb_q, arm_q;
    logic armed, filtered, deliver, overrun;

    // Filter decode: the arm bit counts only in multiprocessor mode
    always_comb begin
        armed    = arm_q && mp_mode_i;
        filtered = armed && !mpbit_i;
        deliver  = done_i && !filtered;
        overrun  = deliver && full_q && !full_clr_i;
    end

    // Data register and data-full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            full_q <= 1'b0;
        end else if (deliver && !overrun) begin
            data_q <= data_i;
            full_q <= 1'b1;
        end else if (full_clr_i) begin
            full_q <= 1'b0;
        end
    end

    // Error flags: setting has priority over the clear strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            ferr_q <= (deliver && !stop_ok_i) || (ferr_q && !err_clr_i);
            ovr_q  <= overrun || (ovr_q && !err_clr_i);
        end
    end

    // Wake arm bit and received address-bit flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            mpb_q <= 1'b0;
        end else if (arm_clr_i) begin
            arm_q <= 1'b0;
            mpb_q <= 1'b0;
        end else begin
            if (arm_set_i)                 arm_q <= 1'b1;
            else if (deliver && armed)     arm_q <= 1'b0;
            if (deliver && mp_mode_i)      mpb_q <= mpbit_i;
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;
    assign ferr_o = ferr_q;
    assign ovr_o  = ovr_q;
    assign mpb_o  = mpb_q;
    assign arm_o  = arm_q;

    // R7: a filtered frame touches no register and no flag
    p_filter_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && arm_q && mp_mode_i && !mpbit_i && !full_clr_i && !err_clr_i && !arm_clr_i)
        |=> ($stable(data_q) && $stable(full_q) && $stable(ferr_q) && $stable(ovr_q) && $stable(mpb_q)));

    // R8: an address frame disarms the filter and sets the address-bit flag
    p_wake_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && arm_q && mp_mode_i && mpbit_i && !arm_set_i && !arm_clr_i) |=> (!arm_q && mpb_q));

    // R5: overrun sets the flag and keeps the old data
    p_overrun_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !(arm_q && mp_mode_i && !mpbit_i) && full_q && !full_clr_i) |=> (ovr_q && $stable(data_q)));

    // R9: disarm strobe clears the address-bit flag
    p_mpb_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm_clr_i |=> (!mpb_q && !arm_q));
endmodule

// File: rtl/mp_uart_rx.sv
// Address-wake asynchronous serial receiver top level.
// Chains the line synchroniser, the frame engine and the status/filter stage, and forms the interrupt requests.
// Assumes os_tick_i pulses OSR times per bit period.
module mp_uart_rx #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              os_tick_i,
    input  logic              rx_en_i,
    input  logic              mp_mode_i,
    input  logic              wake_set_i,
    input  logic              wake_clr_i,
    input  logic              full_clr_i,
    input  logic              err_clr_i,
    input  logic              rx_irq_en_i,
    input  logic              err_irq_en_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              full_o,
    output logic              frame_err_o,
    output logic              overrun_o,
    output logic              addr_bit_o,
    output logic              wake_arm_o,
    output logic              rx_irq_o,
    output logic              err_irq_o
);
    logic              line_s;
    logic              f_done;
    logic [DATA_W-1:0] f_data;
    logic              f_mpbit;
    logic              f_stop;

    mpurx_sync #(.STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (rxd_i),
        .dout_o (line_s)
    );

    mpurx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_en_i),
        .tick_i    (os_tick_i),
        .line_i    (line_s),
        .mp_mode_i (mp_mode_i),
        .done_o    (f_done),
        .data_o    (f_data),
        .mpbit_o   (f_mpbit),
        .stop_ok_o (f_stop)
    );

    mpurx_status #(.DATA_W(DATA_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (f_done),
        .data_i     (f_data),
        .mpbit_i    (f_mpbit),
        .stop_ok_i  (f_stop),
        .mp_mode_i  (mp_mode_i),
        .arm_set_i  (wake_set_i),
        .arm_clr_i  (wake_clr_i),
        .full_clr_i (full_clr_i),
        .err_clr_i  (err_clr_i),
        .data_o     (rx_data_o),
        .full_o     (full_o),
        .ferr_o     (frame_err_o),
        .ovr_o      (overrun_o),
        .mpb_o      (addr_bit_o),
        .arm_o      (wake_arm_o)
    );

    // Interrupt requests gated by their enables
    always_comb begin
        rx_irq_o  = full_o && rx_irq_en_i;
        err_irq_o = (frame_err_o || overrun_o) && err_irq_en_i;
    end
endmodule

// File: tb/mp_uart_rx_tb.sv
// Scoreboard bench: driver tasks update a reference model and queue snapshots; the monitor compares them with the ports.
module mp_uart_rx_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1, tick = 1'b1, rx_en = 1'b0, mp_mode = 1'b0;
    logic wset = 1'b0, wclr = 1'b0, fclr = 1'b0, eclr = 1'b0, rie = 1'b0, eie = 1'b0;
    logic [7:0] rdata;
    logic full, ferr, ovr, mpb, arm, rxi, eri;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        string      req;
        logic [7:0] data;
        logic       full, ferr, ovr, mpb, arm, rxi, eri;
    } exp_t;
    exp_t sb_q[$];
    event chk_ev;

    // reference model
    logic [7:0] m_data = '0;
    logic m_full = 0, m_ferr = 0, m_ovr = 0, m_mpb = 0, m_arm = 0;

    always #2 clk = ~clk;

    mp_uart_rx u_dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .os_tick_i(tick), .rx_en_i(rx_en),
        .mp_mode_i(mp_mode), .wake_set_i(wset), .wake_clr_i(wclr), .full_clr_i(fclr),
        .err_clr_i(eclr), .rx_irq_en_i(rie), .err_irq_en_i(eie), .rx_data_o(rdata),
        .full_o(full), .frame_err_o(ferr), .overrun_o(ovr), .addr_bit_o(mpb),
        .wake_arm_o(arm), .rx_irq_o(rxi), .err_irq_o(eri)
    );

    task automatic cmp(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Queue the model state and wake the monitor
    task automatic expect_now(string req);
        exp_t e;
        e.req = req; e.data = m_data; e.full = m_full; e.ferr = m_ferr; e.ovr = m_ovr;
        e.mpb = m_mpb; e.arm = m_arm;
        e.rxi = m_full & rie;                 // R12
        e.eri = (m_ferr | m_ovr) & eie;       // R12
        sb_q.push_back(e);
        ->chk_ev;
        @(negedge clk);
    endtask

    // Monitor: compare every queued snapshot with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                cmp(e.req, "data", rdata, e.data);
                cmp(e.req, "full", full, e.full);
                cmp(e.req, "frame_err", ferr, e.ferr);
                cmp(e.req, "overrun", ovr, e.ovr);
                cmp(e.req, "addr_bit", mpb, e.mpb);
                cmp(e.req, "wake_arm", arm, e.arm);
                cmp(e.req, "rx_irq", rxi, e.rxi);
                cmp(e.req, "err_irq", eri, e.eri);
            end
        end
    end

    task automatic send_bit(logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    // Drive one frame and update the model
    task automatic send_frame(logic [7:0] d, logic ab, logic stop);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (mp_mode) send_bit(ab);
        send_bit(stop);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
        if (rx_en && !(mp_mode && m_arm && !ab)) begin
            if (mp_mode && m_arm) m_arm = 1'b0;
            if (mp_mode) m_mpb = ab;
            if (m_full) m_ovr = 1'b1;
            else begin m_data = d; m_full = 1'b1; end
            if (!stop) m_ferr = 1'b1;
        end
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
        @(negedge clk);
    endtask

    task automatic clr_full();   pulse(fclr); m_full = 1'b0; endtask
    task automatic clr_err();    pulse(eclr); m_ferr = 1'b0; m_ovr = 1'b0; endtask
    task automatic arm_wake();   pulse(wset); m_arm = 1'b1; endtask
    task automatic disarm_wake(); pulse(wclr); m_arm = 1'b0; m_mpb = 1'b0; endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1");
        rx_en = 1'b1; rie = 1'b1; eie = 1'b1;
        repeat (4) @(negedge clk);
        // R2 R4 R12: plain frame, LSB first
        send_frame(8'hA5, 1'b0, 1'b1); expect_now("R2");
        clr_full(); expect_now("R4");
        send_frame(8'h3C, 1'b0, 1'b1); expect_now("R2");
        // R5: second frame while full
        send_frame(8'h81, 1'b0, 1'b1); expect_now("R5");
        clr_err(); clr_full(); expect_now("R6");
        // R6: stop bit low
        send_frame(8'h5A, 1'b0, 1'b0); expect_now("R6");
        rxd = 1'b1; repeat (20) @(negedge clk);
        clr_err(); clr_full(); expect_now("R12");
        // R3: short low pulse
        rxd = 1'b0; repeat (4) @(negedge clk);
        rxd = 1'b1; repeat (30) @(negedge clk);
        expect_now("R3");
        // R7: armed filter drops data frames
        mp_mode = 1'b1;
        arm_wake(); expect_now("R7");
        send_frame(8'h55, 1'b0, 1'b1); expect_now("R7");
        send_frame(8'hC3, 1'b0, 1'b0); expect_now("R7");
        // R8: address frame wakes
        send_frame(8'h12, 1'b1, 1'b1); expect_now("R8");
        // R9: disarm strobe clears address-bit flag
        disarm_wake(); expect_now("R9");
        clr_full();
        // unarmed multiprocessor frame with address bit 0 is delivered
        send_frame(8'hE7, 1'b0, 1'b1); expect_now("R2");
        clr_full();
        // R10: arm bit ignored outside multiprocessor mode
        mp_mode = 1'b0;
        arm_wake();
        send_frame(8'h77, 1'b0, 1'b1); expect_now("R10");
        // R11: receiver off, flags hold
        rx_en = 1'b0;
        send_frame(8'h0F, 1'b0, 1'b0); expect_now("R11");
        rie = 1'b0; eie = 1'b0;
        @(negedge clk);
        expect_now("R12");
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule